// File: doc/BRIEF.md
# Word-Interleaved Block Memory Controller

This block sits behind a cache and serves its miss traffic from a main memory split into several word-interleaved banks. With the default of four banks, consecutive word addresses fall in consecutive banks, so a four-word cache block has exactly one word in each bank. A block read sends the row address to every bank in a single address cycle. All banks then run their fixed-latency access at the same time. The four words come back over a one-word response path in successive cycles. The whole read costs 1 + 6 + 4 = 11 cycles. A memory that accesses the words one after another would need 4 × (1 + 6 + 1) = 32 cycles.

The cache presents one request at a time on a valid/ready handshake. The request is either a block read or a single-word write. A write goes only to the bank picked by the two lowest word-address bits. It takes the address cycle plus the bank access, and then a one-cycle acknowledge is returned. The banks are modelled inside the block as synthesizable storage with a fixed access latency.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: The bank holding a word is given by word-address bits [1:0]. Within a block, response beat n (n = 0..3) carries the word stored at block base + n, which lives in bank n.
- R2: `req_ready` is 1 when the controller is idle and in the cycle that carries `rd_done` or `wr_ack`, and 0 otherwise. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1.
- R3: If a read is accepted on edge a, its first word is on `rsp_data` with `rsp_valid` = 1 in the cycle that follows edge a+7. This is one address cycle followed by six access cycles.
- R4: `rsp_valid` stays high for exactly four consecutive cycles per block read, with the words in ascending bank order from bank 0. The full block has been delivered 11 cycles after acceptance.
- R5: `rd_done` is high for one cycle, in the cycle right after the last word of a read.
- R6: The two lowest address bits of a read request are ignored. The block base is the address with those bits cleared.
- R7: A write changes only the word at its own address. The other three words of the same block keep their values when the block is read back.
- R8: If a write is accepted on edge a, `wr_ack` is high for exactly one cycle, the cycle after edge a+7.
- R9: While a request is in progress, `req_valid` is not accepted. A request held during that time is taken only when `req_ready` returns, and it is served exactly once.
- R10: While `rst_n` is low, `req_ready` = 1 and `rsp_valid`, `rd_done` and `wr_ack` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = single-word write, 0 = block read |
| req_addr | input | ADDR_W | Word address (bits [1:0] select the bank) |
| req_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | A read word is on rsp_data |
| rsp_data | output | WORD_W | Read word, zero when rsp_valid is low |
| rd_done | output | 1 | One-cycle pulse after the last word of a block |
| wr_ack | output | 1 | One-cycle pulse when a write access completes |

## Verification
A wrong sequencer state or latency count would show up at the ports within the same block transfer. `rsp_valid`, `wr_ack` or `req_ready` would move by one or more cycles against the fixed 8/12-cycle schedule, and the per-cycle comparison catches that on the first shifted beat. A wrong bank select or word index would put the wrong word on `rsp_data` on the very beat it is used. The same applies to a write reaching the wrong bank. Read-back of whole blocks after partial writes exposes such misrouting the next time the block is read.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
package ilv_pkg;

    // Sequencer phases of one request
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_ACCESS = 3'd2,
        ST_XFER   = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/ilv_bank.sv
`timescale 1ns/1ps
// One memory bank: fixed-latency access started by a one-cycle enable.
module ilv_bank #(
    parameter int ROW_W  = 6,
    parameter int WORD_W = 32,
    parameter int LAT    = 6,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rdy
);

    localparam int DEPTH = 2 ** ROW_W;

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  row;
        logic              we;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
        logic              rdy;
    } bank_t;

    localparam bank_t BANK_RST = '{busy: 1'b0, cnt: '0, row: '0, we: 1'b0,
                                   wdata: '0, rdata: '0, rdy: 1'b0};

    logic [WORD_W-1:0] mem [DEPTH];
    bank_t bank_d, bank_q;
    logic  fire;

    // Access happens on the edge that ends the last latency cycle
    assign fire = bank_q.busy && (bank_q.cnt == '0);

    always_comb begin
        bank_d     = bank_q;
        bank_d.rdy = 1'b0;
        if (en) begin
            bank_d.busy  = 1'b1;
            bank_d.cnt   = CNT_W'(LAT - 1);
            bank_d.row   = row;
            bank_d.we    = we;
            bank_d.wdata = wdata;
        end else if (bank_q.busy) begin
            if (fire) begin
                bank_d.busy = 1'b0;
                bank_d.rdy  = 1'b1;
                if (!bank_q.we) begin
                    bank_d.rdata = mem[bank_q.row];
                end
            end else begin
                bank_d.cnt = bank_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= BANK_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fire && bank_q.we) begin
            mem[bank_q.row] <= bank_q.wdata;
        end
    end

    assign rdata = bank_q.rdata;
    assign rdy   = bank_q.rdy;

endmodule

// File: rtl/ilv_seq.sv
`timescale 1ns/1ps
// Request sequencer: address phase, parallel access wait, word beats.
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int NB     = 4,
    parameter int BSEL_W = 2,
    parameter int ADDR_W = 8,
    parameter int ROW_W  = 6,
    parameter int WORD_W = 32,
    parameter int LAT    = 6,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [NB-1:0]     bank_en,
    output logic              bank_we,
    output logic [ROW_W-1:0]  bank_row,
    output logic [WORD_W-1:0] bank_wdata,
    output logic              xfer_valid,
    output logic [BSEL_W-1:0] xfer_idx,
    output logic              rd_done,
    output logic              wr_ack
);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [BSEL_W-1:0] widx;
        logic [ROW_W-1:0]  row;
        logic [BSEL_W-1:0] bank;
        logic              wr;
        logic [WORD_W-1:0] wdata;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: ST_IDLE, cnt: '0, widx: '0, row: '0,
                                 bank: '0, wr: 1'b0, wdata: '0};
    localparam logic [BSEL_W-1:0] LAST_IDX = BSEL_W'(NB - 1);

    seq_t seq_d, seq_q;
    logic accept;

    assign req_ready = (seq_q.state == ST_IDLE) || (seq_q.state == ST_DONE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    seq_d.state = ST_ADDR;
                    seq_d.row   = req_addr[ADDR_W-1:BSEL_W];
                    seq_d.bank  = req_addr[BSEL_W-1:0];
                    seq_d.wr    = req_write;
                    seq_d.wdata = req_wdata;
                    seq_d.widx  = '0;
                end else begin
                    seq_d.state = ST_IDLE;
                end
            end
            ST_ADDR: begin
                seq_d.state = ST_ACCESS;
                seq_d.cnt   = CNT_W'(LAT - 1);
            end
            ST_ACCESS: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = seq_q.wr ? ST_DONE : ST_XFER;
                    seq_d.widx  = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_XFER: begin
                if (seq_q.widx == LAST_IDX) begin
                    seq_d.state = ST_DONE;
                end else begin
                    seq_d.widx = seq_q.widx + 1'b1;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Reads start every bank; a write starts only its own bank
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            bank_en[b] = (seq_q.state == ST_ADDR) &&
                         (!seq_q.wr || (seq_q.bank == BSEL_W'(b)));
        end
    end

    assign bank_we    = seq_q.wr;
    assign bank_row   = seq_q.row;
    assign bank_wdata = seq_q.wdata;
    assign xfer_valid = (seq_q.state == ST_XFER);
    assign xfer_idx   = seq_q.widx;
    assign rd_done    = (seq_q.state == ST_DONE) && !seq_q.wr;
    assign wr_ack     = (seq_q.state == ST_DONE) && seq_q.wr;

endmodule

// File: rtl/ilv_rd_mux.sv
`timescale 1ns/1ps
// Picks the bank word for the current response beat.
module ilv_rd_mux #(
    parameter int NB     = 4,
    parameter int BSEL_W = 2,
    parameter int WORD_W = 32
) (
    input  logic [NB-1:0][WORD_W-1:0] bank_rdata,
    input  logic                      xfer_valid,
    input  logic [BSEL_W-1:0]         xfer_idx,
    output logic                      rsp_valid,
    output logic [WORD_W-1:0]         rsp_data
);

    always_comb begin
        rsp_valid = xfer_valid;
        rsp_data  = xfer_valid ? bank_rdata[xfer_idx] : '0;
    end

endmodule

// File: rtl/ilv_mem_ctrl.sv
`timescale 1ns/1ps
module ilv_mem_ctrl #(
    parameter int NUM_BANKS  = 4,
    parameter int WORD_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int ACCESS_LAT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rd_done,
    output logic              wr_ack
);

    localparam int BSEL_W = $clog2(NUM_BANKS);
    localparam int ROW_W  = ADDR_W - BSEL_W;
    localparam int CNT_W  = $clog2(ACCESS_LAT + 1);

    logic [NUM_BANKS-1:0]             bank_en;
    logic [NUM_BANKS-1:0]             bank_rdy;
    logic                             bank_we;
    logic [ROW_W-1:0]                 bank_row;
    logic [WORD_W-1:0]                bank_wdata;
    logic [NUM_BANKS-1:0][WORD_W-1:0] bank_rdata;
    logic                             xfer_valid;
    logic [BSEL_W-1:0]                xfer_idx;

    ilv_seq #(
        .NB     (NUM_BANKS),
        .BSEL_W (BSEL_W),
        .ADDR_W (ADDR_W),
        .ROW_W  (ROW_W),
        .WORD_W (WORD_W),
        .LAT    (ACCESS_LAT),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .bank_en    (bank_en),
        .bank_we    (bank_we),
        .bank_row   (bank_row),
        .bank_wdata (bank_wdata),
        .xfer_valid (xfer_valid),
        .xfer_idx   (xfer_idx),
        .rd_done    (rd_done),
        .wr_ack     (wr_ack)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ilv_bank #(
            .ROW_W  (ROW_W),
            .WORD_W (WORD_W),
            .LAT    (ACCESS_LAT),
            .CNT_W  (CNT_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bank_en[b]),
            .we    (bank_we),
            .row   (bank_row),
            .wdata (bank_wdata),
            .rdata (bank_rdata[b]),
            .rdy   (bank_rdy[b])
        );
    end

    ilv_rd_mux #(
        .NB     (NUM_BANKS),
        .BSEL_W (BSEL_W),
        .WORD_W (WORD_W)
    ) u_mux (
        .bank_rdata (bank_rdata),
        .xfer_valid (xfer_valid),
        .xfer_idx   (xfer_idx),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
`timescale 1ns/1ps
module ilv_mem_ctrl_chk #(
    parameter int NB  = 4,
    parameter int LAT = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic          rsp_valid,
    input logic          rd_done,
    input logic          wr_ack,
    input logic [NB-1:0] bank_en,
    input logic          bank_we,
    input logic [NB-1:0] bank_rdy
);

    localparam int LW = $clog2(LAT + NB + 4) + 1;
    localparam int RW = $clog2(NB + 1) + 1;
    localparam logic [LW-1:0] FIRST_AT = LW'(LAT + 2);
    localparam logic [LW-1:0] DONE_AT  = LW'(LAT + NB + 2);
    localparam logic [LW-1:0] LAT_MAX  = '1;
    localparam logic [RW-1:0] RUN_FULL = RW'(NB);

    logic [LW-1:0] lat_q;
    logic [RW-1:0] run_q;
    logic          wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
            run_q <= '0;
            wr_q  <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                lat_q <= LW'(1);
                wr_q  <= req_write;
            end else if (lat_q != '0 && lat_q != LAT_MAX) begin
                lat_q <= lat_q + 1'b1;
            end
            run_q <= rsp_valid ? run_q + 1'b1 : '0;
        end
    end

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    first_word_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && run_q == '0) |-> (lat_q == FIRST_AT && !wr_q));

    // R1
    banks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && run_q == '0) |-> (&bank_rdy));

    // R1
    read_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_we && bank_en != '0) |-> (&bank_en));

    // R4
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid && run_q != '0) |-> (run_q == RUN_FULL));

    // R4
    burst_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (run_q < RUN_FULL));

    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (run_q == RUN_FULL && lat_q == DONE_AT));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R7
    write_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && bank_en != '0) |-> ($countones(bank_en) == 1));

    // R8
    wr_ack_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> (wr_q && lat_q == FIRST_AT));

    // R9
    outputs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, rd_done, wr_ack}));

endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(.NB(NUM_BANKS), .LAT(ACCESS_LAT)) u_chk (.*);

// File: tb/ilv_mem_ctrl_tb.sv
`timescale 1ns/1ps
module ilv_mem_ctrl_tb_top;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;
    localparam int LAT    = 6;
    localparam int NB     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORD_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [WORD_W-1:0] rsp_data;
    logic              rd_done;
    logic              wr_ack;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int free_at = 0;
    bit finished = 0;

    logic [WORD_W-1:0] ref_mem [0:255];
    bit                exp_v  [int];
    logic [WORD_W-1:0] exp_d  [int];
    bit                exp_dn [int];
    bit                exp_ak [int];

    always #10 clk = ~clk;

    ilv_mem_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rd_done   (rd_done),
        .wr_ack    (wr_ack)
    );

    task automatic chk(string tag, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Reference schedule for a request accepted on edge a (seen at cyc = a)
    task automatic schedule(int a);
        if (req_write) begin
            ref_mem[req_addr] = req_wdata;
            exp_ak[a + LAT + 1] = 1'b1;          // R8
            free_at = a + LAT + 1;
        end else begin
            for (int k = 0; k < NB; k++) begin
                // R6: base is the address with bits [1:0] cleared
                exp_v[a + LAT + 1 + k] = 1'b1;
                exp_d[a + LAT + 1 + k] = ref_mem[{req_addr[ADDR_W-1:2], 2'(k)}];
            end
            exp_dn[a + LAT + 1 + NB] = 1'b1;     // R5
            free_at = a + LAT + 1 + NB;
        end
    endtask

    task automatic compare();
        chk("R2 req_ready", {31'b0, req_ready}, {31'b0, cyc >= free_at});
        chk("R3 R4 rsp_valid", {31'b0, rsp_valid}, {31'b0, exp_v.exists(cyc)});
        if (exp_v.exists(cyc)) begin
            chk("R1 R4 rsp_data", rsp_data, exp_d[cyc]);
        end
        chk("R5 rd_done", {31'b0, rd_done}, {31'b0, exp_dn.exists(cyc)});
        chk("R8 wr_ack", {31'b0, wr_ack}, {31'b0, exp_ak.exists(cyc)});
    endtask

    // One clock; returns 1 if the present request was taken on this edge
    task automatic step(output bit acc);
        acc = req_valid && (cyc >= free_at);
        if (acc) schedule(cyc + 1);
        @(posedge clk);
        @(negedge clk);
        cyc++;
        compare();
    endtask

    task automatic issue(bit wr, logic [ADDR_W-1:0] addr, logic [WORD_W-1:0] data);
        bit acc;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = data;
        acc = 1'b0;
        // R9: held request waits while the controller is busy
        while (!acc) step(acc);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic idle(int n);
        bit acc;
        for (int i = 0; i < n; i++) step(acc);
    endtask

    initial begin
        bit acc;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 req_ready", {31'b0, req_ready}, 32'd1);
        chk("R10 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R10 rd_done", {31'b0, rd_done}, 32'd0);
        chk("R10 wr_ack", {31'b0, wr_ack}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // Fill blocks 0..3 with single-word writes, back to back (R8, R9)
        for (int w = 0; w < 16; w++) begin
            issue(1'b1, ADDR_W'(w), 32'hA500_0000 ^ (w * 32'h0101_0101) ^ 32'(w));
        end
        idle(3);

        // Block reads with aligned and unaligned addresses (R1, R3, R4, R6)
        issue(1'b0, 8'd0, '0);
        issue(1'b0, 8'd6, '0);   // R6: low bits 2'b10 ignored
        idle(2);
        issue(1'b0, 8'd15, '0);  // R6: low bits 2'b11 ignored

        // R7: one word of block 2 rewritten, neighbours read back unchanged
        issue(1'b1, 8'd9, 32'hDEAD_BEEF);
        issue(1'b0, 8'd8, '0);

        // R7: last bank of block 1 rewritten, then a read of block 3 and block 1
        issue(1'b1, 8'd7, 32'h1234_5678);
        idle(1);
        issue(1'b0, 8'd13, '0);
        issue(1'b0, 8'd5, '0);

        // Write immediately followed by read of the same word (R2, R8)
        issue(1'b1, 8'd0, 32'h0F0F_F0F0);
        issue(1'b0, 8'd1, '0);

        idle(20);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule